// File: doc/BRIEF.md
# Serial Multichannel ADC Readout Controller

This controller runs an external eight-channel, 18-bit successive-approximation converter through its serial output. While enabled, it raises a conversion-start pulse at a fixed programmable interval. It then waits until the conversion is finished. The end of conversion is taken either from the falling edge of the converter's busy line or from a programmable worst-case delay. After that it clocks out all eight results.

The controller is the master of the serial link. It generates the serial clock from the system clock by a programmable half-period divider, drives an active-low chip select, and shifts in one data line MSB first. It offers two framings, chosen by a mode input:

- **Single frame:** one chip-select assertion covers all 144 clocks.
- **Per word:** chip select is released for one serial clock period between the 18-bit words, so each channel takes 19 clock periods.

Each result leaves the block with its channel index and a one-cycle valid strobe. A done pulse marks the last channel of each set. A start request that arrives while a conversion or readout is still running is dropped and recorded in a sticky overrun flag.

Top module: `adc_burst_reader`

## Requirements
- R1: After reset the outputs are idle: `adc_convst`=0, `adc_cs_n`=1, `adc_sclk`=1, `res_valid`=0, `frame_done`=0 and `overrun`=0.
- R2: Start requests while `run`=1:
  - A start request occurs every `cfg_period` system cycles, counted from when `run` rises.
  - An accepted request drives `adc_convst` high for exactly CONV_HI cycles. The default of 4 cycles is 32 ns at 125 MHz.
  - Consecutive rising edges of `adc_convst` are `cfg_period` cycles apart.
- R3: With `use_busy`=0, `adc_cs_n` falls exactly `cfg_wait` cycles after `adc_convst` falls.
- R4: With `use_busy`=1, readout waits for a falling edge of `adc_busy`:
  - `adc_busy` passes through a two-flop synchronizer before edge detection.
  - `adc_cs_n` falls exactly 3 cycles after `adc_busy` goes low.
  - `cfg_wait` has no effect in this mode.
- R5: A set uses 144 falling edges of `adc_sclk`, all with `adc_cs_n` low.
  - Each serial bit is `cfg_half` cycles low followed by `cfg_half` cycles high.
  - `adc_dout` is sampled on the falling edge and assembled MSB first.
  - The converter is expected to present its MSB when chip select falls and to change data on rising edges.
- R6: With `per_word`=1, chip select frames each 18-bit word separately:
  - `adc_cs_n` is asserted 8 times per set.
  - It stays high for exactly 2×`cfg_half` cycles (one serial clock) between words.
- R7: With `per_word`=0, `adc_cs_n` is asserted once per set and stays low for all 144 bits.
- R8: `adc_sclk` stays high and has no edges while `adc_cs_n` is high.
- R9: Each word is presented with a one-cycle `res_valid` pulse:
  - `res_data` holds the 18-bit word.
  - `res_ch` carries the channel index, 0 to 7 in ascending order.
- R10: `frame_done` pulses in the same cycle as the `res_valid` for channel 7, once per set.
- R11: Overrun handling:
  - A start request that arrives while a conversion, wait or readout is in progress is ignored; no extra `adc_convst` pulse occurs.
  - Such a request sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Enables periodic start requests; the interval counter restarts when low |
| per_word | input | 1 | 1: chip select per 18-bit word; 0: one chip select for the whole set |
| use_busy | input | 1 | 1: start readout on busy falling edge; 0: after `cfg_wait` cycles |
| cfg_period | input | 16 | Sample interval in system cycles |
| cfg_wait | input | 16 | Worst-case conversion delay in system cycles |
| cfg_half | input | 8 | Serial clock half period in system cycles |
| adc_busy | input | 1 | Converter busy indication, asynchronous |
| adc_dout | input | 1 | Converter serial data |
| adc_convst | output | 1 | Conversion-start pulse |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| res_data | output | 18 | Received result |
| res_ch | output | 3 | Channel index of `res_data` |
| res_valid | output | 1 | Result strobe |
| frame_done | output | 1 | Last result of a set |
| overrun | output | 1 | Sticky dropped-request flag |

## Verification
The bench pairs the controller with a behavioural converter model. The model loads a known 144-bit pattern at each start pulse and shifts on rising serial clock edges. Against this model the bench checks the following, each tied to the fault it exposes:

- **Word gap between per-word frames.** A gap that is off by one half period, or a model shift lost at chip-select release, corrupts the next word.
- **Single-frame versus per-word framing.** A design that ignores the mode shows the wrong number of chip-select assertions.
- **Exact wait delay in timeout mode.** An off-by-one wait counter moves the first chip-select fall by a cycle.
- **Exact three-cycle latency after busy falls,** with `cfg_wait` set short. A design that uses the timeout in busy mode, or skips the synchronizer, starts the read too early.
- **Start interval shorter than a set.** A design that queues or honours the overlapping request emits a start pulse during a readout or fails to set the overrun flag.

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int DATA_W  = 18,
  parameter int NUM_CH  = 8,
  parameter int CONV_HI = 4,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              per_word,
  input  logic              use_busy,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_wait,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              adc_busy,
  input  logic              adc_dout,
  output logic              adc_convst,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic [DATA_W-1:0] res_data,
  output logic [$clog2(NUM_CH)-1:0] res_ch,
  output logic              res_valid,
  output logic              frame_done,
  output logic              overrun
);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int HALF_LAST = 2*DATA_W - 1;
  localparam int HALF_W    = $clog2(2*DATA_W + 2);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT, S_READ} state_t;
  state_t st;

  logic [CNT_W-1:0]  per_cnt, tmr;
  logic [DIV_W-1:0]  div_cnt;
  logic [HALF_W-1:0] half;
  logic [CH_W-1:0]   ch;
  logic [DATA_W-2:0] shreg;
  logic [2:0]        bsy_q;

  wire busy_fall = bsy_q[2] & ~bsy_q[1];
  wire start_req = run && (({1'b0, per_cnt} + 1'b1) >= {1'b0, cfg_period});
  wire wait_done = ({1'b0, tmr} + 1'b1) >= {1'b0, cfg_wait};
  wire tick      = ({1'b0, div_cnt} + 1'b1) >= {1'b0, cfg_half};
  wire last_ch   = (ch == CH_W'(NUM_CH-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bsy_q <= '0;
    else        bsy_q <= {bsy_q[1:0], adc_busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 per_cnt <= '0;
    else if (!run || start_req) per_cnt <= '0;
    else                        per_cnt <= per_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      div_cnt <= '0;
      half <= '0;
      ch <= '0;
      shreg <= '0;
      adc_convst <= 1'b0;
      adc_cs_n <= 1'b1;
      adc_sclk <= 1'b1;
      res_data <= '0;
      res_ch <= '0;
      res_valid <= 1'b0;
      frame_done <= 1'b0;
      overrun <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      frame_done <= 1'b0;
      if (start_req && st != S_IDLE) overrun <= 1'b1;
      case (st)
        S_IDLE: if (start_req) begin
          st <= S_CONV;
          adc_convst <= 1'b1;
          tmr <= '0;
        end
        S_CONV: begin
          if (tmr == CNT_W'(CONV_HI-1)) begin
            adc_convst <= 1'b0;
            st <= S_WAIT;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_WAIT: begin
          if (use_busy ? busy_fall : wait_done) begin
            st <= S_READ;
            adc_cs_n <= 1'b0;
            half <= '0;
            ch <= '0;
            div_cnt <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_READ: begin
          if (!tick) div_cnt <= div_cnt + 1'b1;
          else begin
            div_cnt <= '0;
            if (half > HALF_W'(HALF_LAST)) begin
              if (half == HALF_W'(HALF_LAST+2)) begin
                adc_cs_n <= 1'b0;
                half <= '0;
              end else half <= half + 1'b1;
            end else if (!half[0]) begin
              adc_sclk <= 1'b0;
              shreg <= {shreg[DATA_W-3:0], adc_dout};
              half <= half + 1'b1;
              if (half == HALF_W'(HALF_LAST-1)) begin
                res_data <= {shreg, adc_dout};
                res_ch <= ch;
                res_valid <= 1'b1;
                frame_done <= last_ch;
              end
            end else begin
              adc_sclk <= 1'b1;
              if (half == HALF_W'(HALF_LAST)) begin
                if (last_ch) begin
                  adc_cs_n <= 1'b1;
                  st <= S_IDLE;
                end else begin
                  ch <= ch + 1'b1;
                  if (per_word) begin
                    adc_cs_n <= 1'b1;
                    half <= half + 1'b1;
                  end else half <= '0;
                end
              end else half <= half + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_burst_reader_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_convst,
  input logic            adc_cs_n,
  input logic            adc_sclk,
  input logic [CH_W-1:0] res_ch,
  input logic            res_valid,
  input logic            frame_done,
  input logic            overrun
);
  p_sclk_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);
  p_valid_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !adc_cs_n);
  p_done_on_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (res_valid && res_ch == CH_W'(NUM_CH-1)));
  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_convst_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst |-> adc_cs_n);
  p_convst_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst) |=> adc_convst);
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_convst(adc_convst), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .res_ch(res_ch), .res_valid(res_valid),
  .frame_done(frame_done), .overrun(overrun)
);

// File: tb/test_adc_burst_reader.sv
module test_adc_burst_reader;
  localparam int BUSY_CYC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, per_word = 1'b1, use_busy = 1'b0;
  logic [15:0] cfg_period = 16'd2000, cfg_wait = 16'd80;
  logic [7:0]  cfg_half = 8'd2;
  logic adc_convst, adc_cs_n, adc_sclk, res_valid, frame_done, overrun;
  logic [17:0] res_data;
  logic [2:0]  res_ch;

  logic [143:0] m_sr = '0;
  logic m_busy = 1'b0;
  int   m_busy_cnt = 0;
  int   m_frame = 0;
  logic conv_q = 0, sclk_q = 1, cs_q = 1;

  always #4 clk = ~clk;

  adc_burst_reader i_adc_burst_reader (
    .clk(clk), .rst_n(rst_n), .run(run), .per_word(per_word), .use_busy(use_busy),
    .cfg_period(cfg_period), .cfg_wait(cfg_wait), .cfg_half(cfg_half),
    .adc_busy(m_busy), .adc_dout(m_sr[143]),
    .adc_convst(adc_convst), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .res_data(res_data), .res_ch(res_ch), .res_valid(res_valid),
    .frame_done(frame_done), .overrun(overrun)
  );

  function automatic logic [17:0] exp_word(int k, int i);
    return 18'((k * 40503 + i * 9157 + 'h15a5a) ^ (i << 14));
  endfunction

  function automatic logic [143:0] build(int k);
    logic [143:0] v = '0;
    for (int i = 0; i < 8; i++) v[143 - 18*i -: 18] = exp_word(k, i);
    return v;
  endfunction

  always @(posedge clk) begin
    conv_q <= adc_convst;
    sclk_q <= adc_sclk;
    cs_q <= adc_cs_n;
    if (adc_sclk && !sclk_q && !cs_q) m_sr <= m_sr << 1;
    if (adc_convst && !conv_q) begin
      m_frame <= m_frame + 1;
      m_sr <= build(m_frame + 1);
      m_busy <= 1'b1;
      m_busy_cnt <= BUSY_CYC;
    end else if (m_busy) begin
      if (m_busy_cnt <= 1) m_busy <= 1'b0;
      m_busy_cnt <= m_busy_cnt - 1;
    end
  end

  int cyc = 0, conv_rises, last_rise, prev_rise, hi_cnt, conv_len, conv_fall;
  int first_cs, cs_rise, cs_falls, gap_min, gap_max, sclk_falls, bad_edges;
  int busy_fall, dones, cap_n, overlap;
  bit await_cs, in_flight;
  logic [17:0] cap_d [64];
  logic [2:0]  cap_c [64];
  logic p_conv = 0, p_cs = 1, p_sclk = 1, p_busy = 0;

  always @(negedge clk) begin
    cyc++;
    if (adc_convst && !p_conv) begin
      conv_rises++; prev_rise = last_rise; last_rise = cyc;
      if (in_flight) overlap++;
      in_flight = 1;
    end
    if (adc_convst) hi_cnt = p_conv ? hi_cnt + 1 : 1;
    if (!adc_convst && p_conv) begin conv_len = hi_cnt; conv_fall = cyc; await_cs = 1; end
    if (!adc_cs_n && p_cs) begin
      cs_falls++;
      if (await_cs) begin first_cs = cyc; await_cs = 0; end
      else begin
        if (cyc - cs_rise < gap_min) gap_min = cyc - cs_rise;
        if (cyc - cs_rise > gap_max) gap_max = cyc - cs_rise;
      end
    end
    if (adc_cs_n && !p_cs) cs_rise = cyc;
    if (!adc_sclk && p_sclk) begin
      if (adc_cs_n) bad_edges++; else sclk_falls++;
    end
    if (!m_busy && p_busy) busy_fall = cyc;
    if (res_valid && cap_n < 64) begin cap_d[cap_n] = res_data; cap_c[cap_n] = res_ch; cap_n++; end
    if (frame_done) begin dones++; in_flight = 0; end
    p_conv = adc_convst; p_cs = adc_cs_n; p_sclk = adc_sclk; p_busy = m_busy;
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    conv_rises = 0; cs_falls = 0; sclk_falls = 0; bad_edges = 0; dones = 0;
    cap_n = 0; overlap = 0; gap_min = 1000000; gap_max = 0; await_cs = 0;
    in_flight = 0;
  endtask

  task automatic wait_done(int n);
    while (dones < n) @(negedge clk);
  endtask

  task automatic one_frame(logic pw, logic ub, int w, int h);
    @(negedge clk);
    per_word = pw; use_busy = ub; cfg_wait = 16'(w); cfg_half = 8'(h);
    cfg_period = 16'd2000;
    clear_mon();
    run = 1'b1;
    wait_done(1);
    run = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic check_set(string req, int base);
    for (int i = 0; i < 8; i++) begin
      chk({req, " channel index"}, cap_c[base+i], i);
      chk({req, " data"}, cap_d[base+i], exp_word(m_frame, i));
    end
  endtask

  task automatic t_reset();
    chk("R1 convst", adc_convst, 0);
    chk("R1 cs_n", adc_cs_n, 1);
    chk("R1 sclk", adc_sclk, 1);
    chk("R1 valid", res_valid, 0);
    chk("R1 frame_done", frame_done, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_word_frame();
    one_frame(1'b1, 1'b0, 80, 2);
    chk("R2 convst width", conv_len, 4);
    chk("R3 wait delay", first_cs - conv_fall, 80);
    chk("R6 cs assertions", cs_falls, 8);
    chk("R6 min word gap", gap_min, 4);
    chk("R6 max word gap", gap_max, 4);
    chk("R5 sclk falls", sclk_falls, 144);
    chk("R8 edges with cs high", bad_edges, 0);
    chk("R9 result count", cap_n, 8);
    check_set("R9", 0);
    chk("R10 done pulses", dones, 1);
    chk("R1 cs idle after set", adc_cs_n, 1);
  endtask

  task automatic t_cont_frame();
    one_frame(1'b0, 1'b0, 30, 3);
    chk("R7 cs assertions", cs_falls, 1);
    chk("R3 wait delay", first_cs - conv_fall, 30);
    chk("R5 sclk falls", sclk_falls, 144);
    chk("R8 edges with cs high", bad_edges, 0);
    chk("R9 result count", cap_n, 8);
    check_set("R5", 0);
  endtask

  task automatic t_busy();
    one_frame(1'b1, 1'b1, 2, 2);
    chk("R4 busy to cs latency", first_cs - busy_fall, 3);
    chk("R4 result count", cap_n, 8);
    check_set("R4", 0);
  endtask

  task automatic t_period();
    @(negedge clk);
    per_word = 1'b1; use_busy = 1'b0; cfg_wait = 16'd80; cfg_half = 8'd2;
    cfg_period = 16'd900;
    clear_mon();
    run = 1'b1;
    wait_done(2);
    run = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 start interval", last_rise - prev_rise, 900);
    chk("R2 start count", conv_rises, 2);
    chk("R11 no overrun", overrun, 0);
    check_set("R9 second set", 8);
  endtask

  task automatic t_overrun();
    @(negedge clk);
    per_word = 1'b1; use_busy = 1'b0; cfg_wait = 16'd80; cfg_half = 8'd2;
    cfg_period = 16'd300;
    clear_mon();
    run = 1'b1;
    wait_done(2);
    run = 1'b0;
    repeat (1500) @(negedge clk);
    chk("R11 overrun set", overrun, 1);
    chk("R11 start during readout", overlap, 0);
    chk("R11 sets completed", dones, conv_rises);
    check_set("R11 last set", cap_n - 8);
    one_frame(1'b1, 1'b0, 80, 2);
    chk("R11 overrun sticky", overrun, 1);
    check_set("R11 set after overrun", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_frame();
    t_cont_frame();
    t_busy();
    t_period();
    t_overrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule